// File: doc/BRIEF.md
# NAND Page ECC Parity Accumulator

This block builds the Hamming-style parity of a NAND flash data page as the page streams past, one byte per cycle that carries a valid strobe. Each accepted byte is reduced to a set of six group parities and one overall parity. The group parities fold into a column parity register. The overall parity decides whether the running byte index, and its bitwise complement, fold into two line parity registers. A free-running byte counter supplies that index.

The data byte is returned unchanged in the same cycle, so the block can sit directly in a controller's data path. All four state registers are visible on output ports at all times. A synchronous clear command resets the accumulation at the start of a page. The asynchronous active-low reset is released through a synchroniser.

Top module: `nand_ecc_accum`

## Requirements
- R1: While reset is held, and until the first accepted byte after it, the column parity, both line parities and the byte counter all read zero.
- R2: A cycle with `clr_i` high sets the column parity, both line parities and the counter to zero at the next clock edge.
- R3: For each accepted byte d, group code bits are g0=^(d&0x55), g1=^(d&0xAA), g2=^(d&0x33), g3=^(d&0xCC), g4=^(d&0x0F), g5=^(d&0xF0). The value {g5..g0} is XORed into column parity bits 5:0, and bits 7:6 always read zero. For example, a single byte 0x01 gives 0x15, 0x02 gives 0x16, 0x03 gives 0x03, and 0xFF gives 0x00.
- R4: When an accepted byte has odd parity (^d = 1), line parity 0 is XORed with the bitwise inverse of the counter value held before this byte, and line parity 1 is XORed with that counter value.
- R5: An accepted byte with even parity leaves both line parity registers unchanged.
- R6: The counter rises by one for every accepted byte, whatever its parity, and wraps from 65535 to 0.
- R7: When `clr_i` and `vld_i` are high in the same cycle, the clear takes effect and the byte is not digested. The counter then reads zero and the parities read zero.
- R8: `dat_o` equals `dat_i` in the same cycle, whether or not the byte is valid.
- R9: A cycle with `vld_i` low and `clr_i` low leaves all four state registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low, released synchronously |
| clr_i | input | 1 | Synchronous clear of the accumulated state |
| vld_i | input | 1 | Byte on `dat_i` is accepted this cycle |
| dat_i | input | 8 | Data byte in |
| dat_o | output | 8 | Data byte out, same as `dat_i` |
| col_par_o | output | 8 | Column parity register |
| line_par0_o | output | 16 | Line parity register folded with inverted indices |
| line_par1_o | output | 16 | Line parity register folded with true indices |
| byte_cnt_o | output | 16 | Accepted byte counter |

## Verification
Every state register drives an output port directly. A wrong group parity, a missed or extra fold, or a wrong index therefore shows on `col_par_o`, the line parity ports or `byte_cnt_o` in the cycle after the byte that caused it, and it remains visible until the next clear. Because each fold is an XOR, a single misdigested byte cannot be cancelled later by a correct stream. The two line parity ports must always differ by either all zeros or all ones. An index fault that hits only one of them breaks that relation at once.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

  // Width of one data sample handled per cycle.
  localparam int BYTE_W = 8;
  // Number of binary levels in a byte index (three for eight bits).
  localparam int BIT_LVL = $clog2(BYTE_W);
  // Group parities produced per byte: one even/odd pair per level.
  localparam int GRP_W = 2 * BIT_LVL;
  // Column register width: group parities plus two always-zero bits.
  localparam int COL_W = GRP_W + 2;
  // Byte index and line parity width.
  localparam int IDX_W = 16;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [GRP_W-1:0]  grp_t;
  typedef logic [IDX_W-1:0]  idx_t;

endpackage

// File: rtl/nand_ecc_rst_sync.sv
module nand_ecc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_no = shift_q[STAGES-1];

endmodule

// File: rtl/nand_ecc_byte_code.sv
module nand_ecc_byte_code
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W = BYTE_W,
  localparam int LVL   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  dat_i,
  output logic [2*LVL-1:0]   grp_o,
  output logic               odd_o
);

  // For index level k, the even member of the pair takes the bits whose
  // index has bit k clear. The odd member takes the bits whose index has
  // bit k set.
  for (genvar k = 0; k < LVL; k++) begin : g_lvl
    logic lo_par;
    logic hi_par;

    always_comb begin
      lo_par = 1'b0;
      hi_par = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
        if (((i >> k) & 1) == 0) begin
          lo_par = lo_par ^ dat_i[i];
        end else begin
          hi_par = hi_par ^ dat_i[i];
        end
      end
    end

    assign grp_o[2*k]   = lo_par;
    assign grp_o[2*k+1] = hi_par;
  end

  assign odd_o = ^dat_i;

endmodule

// File: rtl/nand_ecc_line_fold.sv
module nand_ecc_line_fold #(
  parameter int IDX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             fold_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] inv_par_o,
  output logic [IDX_W-1:0] true_par_o
);

  logic [IDX_W-1:0] inv_q;
  logic [IDX_W-1:0] inv_d;
  logic [IDX_W-1:0] true_q;
  logic [IDX_W-1:0] true_d;
  logic             upd_en;

  assign upd_en = clr_i | fold_i;

  always_comb begin
    if (clr_i) begin
      inv_d  = '0;
      true_d = '0;
    end else begin
      inv_d  = inv_q ^ ~idx_i;
      true_d = true_q ^ idx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_q  <= '0;
      true_q <= '0;
    end else if (upd_en) begin
      inv_q  <= inv_d;
      true_q <= true_d;
    end
  end

  assign inv_par_o  = inv_q;
  assign true_par_o = true_q;

endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
  import nand_ecc_pkg::*;
#(
  parameter int  DATA_W     = BYTE_W,
  parameter int  CNT_W      = IDX_W,
  parameter int  RST_STAGES = 2,
  localparam int LVL        = $clog2(DATA_W),
  localparam int GW         = 2 * LVL,
  localparam int CW         = GW + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic [DATA_W-1:0] dat_o,
  output logic [CW-1:0]     col_par_o,
  output logic [CNT_W-1:0]  line_par0_o,
  output logic [CNT_W-1:0]  line_par1_o,
  output logic [CNT_W-1:0]  byte_cnt_o
);

  logic             rst_n_sync;
  logic [GW-1:0]    grp;
  logic             odd;
  logic             accept;

  logic [CW-1:0]    col_q;
  logic [CW-1:0]    col_d;
  logic             col_en;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  nand_ecc_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  nand_ecc_byte_code #(
    .DATA_W (DATA_W)
  ) u_code (
    .dat_i  (dat_i),
    .grp_o  (grp),
    .odd_o  (odd)
  );

  // A clear takes precedence over a byte offered in the same cycle.
  assign accept = vld_i & ~clr_i;

  // Column parity register
  assign col_en = clr_i | accept;

  always_comb begin
    if (clr_i) begin
      col_d = '0;
    end else begin
      col_d = col_q ^ {{(CW-GW){1'b0}}, grp};
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      col_q <= '0;
    end else if (col_en) begin
      col_q <= col_d;
    end
  end

  // Byte counter, wraps silently
  assign cnt_en = clr_i | accept;

  always_comb begin
    if (clr_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // The line parity registers fold the counter value from before the increment.
  nand_ecc_line_fold #(
    .IDX_W      (CNT_W)
  ) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .clr_i      (clr_i),
    .fold_i     (accept & odd),
    .idx_i      (cnt_q),
    .inv_par_o  (line_par0_o),
    .true_par_o (line_par1_o)
  );

  assign dat_o      = dat_i;
  assign col_par_o  = col_q;
  assign byte_cnt_o = cnt_q;

endmodule

// File: rtl/nand_ecc_accum_chk.sv
module nand_ecc_accum_chk #(
  parameter int DATA_W = 8,
  parameter int CW     = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              clr_i,
  input logic              vld_i,
  input logic [DATA_W-1:0] dat_i,
  input logic [CW-1:0]     col_par_o,
  input logic [CNT_W-1:0]  line_par0_o,
  input logic [CNT_W-1:0]  line_par1_o,
  input logic [CNT_W-1:0]  byte_cnt_o
);

  // R2 / R7: a clear empties every register at the next edge.
  p_clear_empties_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    clr_i |=> (col_par_o == '0 && line_par0_o == '0 &&
               line_par1_o == '0 && byte_cnt_o == '0));

  // R3: the two top column bits never become set.
  p_col_top_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    col_par_o[CW-1:CW-2] == 2'b00);

  // R4: the line registers always differ by all zeros or all ones.
  p_line_pair_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((line_par0_o ^ line_par1_o) == '0) || ((line_par0_o ^ line_par1_o) == '1));

  // R5: a byte with even parity does not move the line registers.
  p_even_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (vld_i && !clr_i && !(^dat_i)) |=> ($stable(line_par0_o) && $stable(line_par1_o)));

  // R6: each accepted byte advances the counter by exactly one.
  p_count_step_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (vld_i && !clr_i) |=> (byte_cnt_o == $past(byte_cnt_o) + 1'b1));

  // R9: an idle cycle holds all state.
  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!vld_i && !clr_i) |=> ($stable(col_par_o) && $stable(line_par0_o) &&
                            $stable(line_par1_o) && $stable(byte_cnt_o)));

endmodule

bind nand_ecc_accum nand_ecc_accum_chk #(
  .DATA_W (DATA_W),
  .CW     (CW),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n_sync),
  .clr_i       (clr_i),
  .vld_i       (vld_i),
  .dat_i       (dat_i),
  .col_par_o   (col_par_o),
  .line_par0_o (line_par0_o),
  .line_par1_o (line_par1_o),
  .byte_cnt_o  (byte_cnt_o)
);

// File: tb/tb_nand_ecc_accum.sv
module tb_nand_ecc_accum;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        clr_i;
  logic        vld_i;
  logic [7:0]  dat_i;
  logic [7:0]  dat_o;
  logic [7:0]  col_par_o;
  logic [15:0] line_par0_o;
  logic [15:0] line_par1_o;
  logic [15:0] byte_cnt_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Behavioural reference state
  int m_col, m_l0, m_l1, m_cnt;

  always #2 clk_i = ~clk_i;

  nand_ecc_accum dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .vld_i       (vld_i),
    .dat_i       (dat_i),
    .dat_o       (dat_o),
    .col_par_o   (col_par_o),
    .line_par0_o (line_par0_o),
    .line_par1_o (line_par1_o),
    .byte_cnt_o  (byte_cnt_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int code_of(input int d);
    int c = 0;
    int masks[6] = '{8'h55, 8'hAA, 8'h33, 8'hCC, 8'h0F, 8'hF0};
    for (int j = 0; j < 6; j++)
      if ($countones(d & masks[j]) % 2 == 1) c |= (1 << j);
    if ($countones(d & 8'hFF) % 2 == 1) c |= 8'h40;
    return c;
  endfunction

  task automatic compare_all();
    check("R3 column parity", int'(col_par_o), m_col);
    check("R4 line parity 0", int'(line_par0_o), m_l0);
    check("R4 line parity 1", int'(line_par1_o), m_l1);
    check("R6 byte counter", int'(byte_cnt_o), m_cnt);
  endtask

  // One clock cycle: drive after an edge, check the pass-through, then
  // advance the model at the next edge and compare.
  task automatic step(input bit v, input bit c, input int d);
    int code;
    vld_i = v;
    clr_i = c;
    dat_i = d[7:0];
    #1;
    check("R8 pass-through", int'(dat_o), d & 8'hFF);
    @(posedge clk_i);
    #1;
    if (c) begin
      m_col = 0; m_l0 = 0; m_l1 = 0; m_cnt = 0;
    end else if (v) begin
      code  = code_of(d);
      m_col = m_col ^ (code & 8'h3F);
      if ((code & 8'h40) != 0) begin
        m_l0 = m_l0 ^ (~m_cnt & 16'hFFFF);
        m_l1 = m_l1 ^ m_cnt;
      end
      m_cnt = (m_cnt + 1) % 65536;
    end
    compare_all();
  endtask

  task automatic single_code(input int d, input int exp_col);
    step(1'b0, 1'b1, 0);
    step(1'b1, 1'b0, d);
    check("R3 known byte code", int'(col_par_o), exp_col);
  endtask

  initial begin
    rst_ni = 1'b0;
    clr_i  = 1'b0;
    vld_i  = 1'b0;
    dat_i  = 8'h00;
    m_col = 0; m_l0 = 0; m_l1 = 0; m_cnt = 0;
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 reset column", int'(col_par_o), 0);
    check("R1 reset line0", int'(line_par0_o), 0);
    check("R1 reset line1", int'(line_par1_o), 0);
    check("R1 reset counter", int'(byte_cnt_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);
    #1;
    compare_all();

    // Known per-byte codes (R3)
    single_code(8'h01, 8'h15);
    single_code(8'h02, 8'h16);
    single_code(8'h03, 8'h03);
    single_code(8'hFF, 8'h00);
    single_code(8'h00, 8'h00);

    // Odd byte folds the pre-increment counter (R4)
    step(1'b0, 1'b1, 0);
    step(1'b1, 1'b0, 8'h00);
    step(1'b1, 1'b0, 8'h00);
    step(1'b1, 1'b0, 8'h80);
    check("R4 inverse of index 2", int'(line_par0_o), 16'hFFFD);
    check("R4 true index 2", int'(line_par1_o), 16'h0002);

    // Even-parity bytes leave line parity alone (R5)
    step(1'b1, 1'b0, 8'h81);
    step(1'b1, 1'b0, 8'hC3);
    check("R5 even line0 held", int'(line_par0_o), 16'hFFFD);
    check("R5 even line1 held", int'(line_par1_o), 16'h0002);

    // Idle cycles hold state (R9)
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, $urandom_range(0, 255));
    check("R9 idle counter held", int'(byte_cnt_o), 5);

    // Clear with a simultaneous byte (R7, R2)
    step(1'b1, 1'b1, 8'h01);
    check("R7 clear wins counter", int'(byte_cnt_o), 0);
    check("R7 clear wins column", int'(col_par_o), 0);
    check("R2 clear line0", int'(line_par0_o), 0);

    // Random streams with random gaps and occasional clears
    for (int s = 0; s < 12; s++) begin
      int len = $urandom_range(1, 300);
      for (int i = 0; i < len; i++) begin
        bit v = ($urandom_range(0, 9) < 8);
        bit c = ($urandom_range(0, 99) == 0);
        step(v, c, $urandom_range(0, 255));
      end
    end

    // All-0xFF stream: column and line parity remain zero (R3, R5)
    step(1'b0, 1'b1, 0);
    for (int i = 0; i < 300; i++) step(1'b1, 1'b0, 8'hFF);
    check("R5 all-ones line0", int'(line_par0_o), 0);
    check("R3 all-ones column", int'(col_par_o), 0);

    // All-0x00 stream across the counter wrap (R6)
    step(1'b0, 1'b1, 0);
    for (int i = 0; i < 65536 + 5; i++) step(1'b1, 1'b0, 8'h00);
    check("R6 counter wrapped", int'(byte_cnt_o), 5);
    step(1'b1, 1'b0, 8'h10);
    check("R4 fold after wrap", int'(line_par1_o), 16'h0005);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule